// File: doc/BRIEF.md
# Audio Serial Clock Divider Chain

This block produces, for each of a transmit and a receive path, a master audio clock and a serial bit clock. Both are derived from one of two source clocks by a cascade of dividers. Each source arrives as a one-cycle enable pulse in the system clock domain. The cascade has four stages:

- an optional divide-by-eight prescaler P;
- a modulus divider M;
- a toggle stage that halves the rate and gives a square wave;
- a fine divider F, used only on the bit-clock branch.

Each output is given two ways: as a one-cycle clock-enable pulse at its rising edge, and as a level for a pad.

Software writes a 16-bit setting word for one path through a single write port. The word sets the divider values, the source, the master-clock pad direction and a direct-output option. With the pad set as an input, the path counts pulses from an external master clock instead of a source. A new setting is held in a shadow register. It takes effect only at the end of a bit-clock high/low cycle, or at once when the path is idle, so that no clock phase is cut short.

Top module: `aclk_div_chain`

## Requirements
- R1: The setting word is laid out as follows, and each divisor field holds its value minus one.
  - bits [7:0]: M minus one.
  - bits [11:8]: F minus one.
  - bit 12: prescaler enable (P=8; P=1 when clear).
  - bit 13: source select (1 selects source B).
  - bit 14: master-clock pad drive (1 = output).
  - bit 15: direct output.
- R2: The bit clock period is 2×P×M×F base ticks. The base tick is the selected source's enable, or the external enable when the pad is an input.
- R3: The master clock period is 2×P×M base ticks, independent of F.
- R4: The bit-clock pad is high for exactly P×M×F base ticks of each period, for odd F as well. Its pulse output fires only on the pad's rising edge. The pad changes only on a base tick.
- R5: When source A is selected, the pad is driven and the direct bit is set, the master clock pulse follows source A's enable one cycle later, undivided. The bit clock is still divided from source A.
- R6: The direct bit has no effect when source B is selected: the master clock stays divided.
- R7: Source select picks which enable input feeds the dividers of a path.
- R8: With the pad drive bit clear, the master-clock pad and its output enable stay low. The master clock pulse follows the external enable one cycle later. The bit clock is divided from the external enable.
- R9: A write to one path leaves the other path's clocks unchanged.
- R10: A new setting takes effect at the next falling edge of the bit clock. The high phase in progress completes with the old setting. A path with no base tick and all counters at zero takes the new setting at once.
- R11: A synchronous reset clears all counters and settings and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Setting write strobe |
| wr_path | input | 1 | Path written: 0 transmit, 1 receive |
| wr_data | input | 16 | Setting word (layout in R1) |
| src_a_en | input | 1 | Source A enable pulse |
| src_b_en | input | 1 | Source B enable pulse |
| ext_hck_en | input | 2 | External master clock enable pulse per path |
| hck_pulse | output | 2 | Master clock enable pulse per path |
| hck_pad | output | 2 | Master clock pad level per path |
| hck_pad_oe | output | 2 | Master clock pad output enable per path |
| sck_pulse | output | 2 | Bit clock enable pulse per path |
| sck_pad | output | 2 | Bit clock pad level per path |

## Verification
The assertions check on every cycle:

- the bit-clock pad moves only on a base tick, and its pulse marks only a rising edge;
- a divided master clock pulse always coincides with a high pad;
- in direct mode the master pulse copies source A's enable;
- in input mode the pad and its enable stay low;
- the cycle after reset leaves every output low.

The actual ratios need the bench's scenarios, because they are counted over whole periods. These cover the prescaler, odd fine divisors, source select, the external clock, direct mode ignored for source B, path independence, and the mixed period around a mid-cycle reload.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef enum logic [1:0] {
    DM_EXT    = 2'd0,
    DM_DIRECT = 2'd1,
    DM_DIV    = 2'd2
  } dmode_e;
endpackage

// File: rtl/aclk_cfg_decode.sv
module aclk_cfg_decode #(
  parameter int N_PATH = 2,
  localparam int PATH_W = (N_PATH > 1) ? $clog2(N_PATH) : 1
) (
  input  logic              wr_en,
  input  logic [PATH_W-1:0] wr_path,
  output logic [N_PATH-1:0] wr_stb
);
  always_comb begin
    wr_stb = '0;
    for (int i = 0; i < N_PATH; i++)
      if (wr_en && (wr_path == PATH_W'(i))) wr_stb[i] = 1'b1;
  end
endmodule

// File: rtl/aclk_div_path.sv
module aclk_div_path
  import aclk_pkg::*;
#(
  parameter int M_W = 8,
  parameter int F_W = 4,
  localparam int CFG_W = M_W + F_W + 4,
  localparam int PRE_W = 3,
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(7)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             src_a_en,
  input  logic             src_b_en,
  input  logic             ext_en,
  output logic             hck_pulse,
  output logic             hck_pad,
  output logic             hck_pad_oe,
  output logic             sck_pulse,
  output logic             sck_pad
);
  logic [CFG_W-1:0] shadow, active;
  logic             pending;
  logic [PRE_W-1:0] pre_cnt;
  logic [M_W-1:0]   mod_cnt;
  logic [F_W-1:0]   fine_cnt;
  logic             hck_q, sck_q;

  logic [M_W-1:0] m_lim;
  logic [F_W-1:0] f_lim;
  logic pre8, sel_b, drive, direct;
  dmode_e mode;
  logic base, pre_wrap, half, fine_wrap, boundary, at_start, load;

  assign m_lim  = active[M_W-1:0];
  assign f_lim  = active[M_W +: F_W];
  assign pre8   = active[M_W+F_W];
  assign sel_b  = active[M_W+F_W+1];
  assign drive  = active[M_W+F_W+2];
  assign direct = active[M_W+F_W+3];

  always_comb begin
    if (!drive)                mode = DM_EXT;
    else if (direct && !sel_b) mode = DM_DIRECT;
    else                       mode = DM_DIV;
  end

  assign base      = (mode == DM_EXT) ? ext_en : (sel_b ? src_b_en : src_a_en);
  assign pre_wrap  = !pre8 || (pre_cnt == PRE_LAST);
  assign half      = base && pre_wrap && (mod_cnt == m_lim);
  assign fine_wrap = (fine_cnt == f_lim);
  assign boundary  = half && fine_wrap && sck_q;
  assign at_start  = (pre_cnt == '0) && (mod_cnt == '0) && (fine_cnt == '0)
                     && !hck_q && !sck_q;
  assign load      = pending && (boundary || (at_start && !base));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow     <= '0;
      active     <= '0;
      pending    <= 1'b0;
      pre_cnt    <= '0;
      mod_cnt    <= '0;
      fine_cnt   <= '0;
      hck_q      <= 1'b0;
      sck_q      <= 1'b0;
      hck_pulse  <= 1'b0;
      hck_pad    <= 1'b0;
      hck_pad_oe <= 1'b0;
      sck_pulse  <= 1'b0;
    end else begin
      if (wr_stb) begin
        shadow  <= wr_data;
        pending <= 1'b1;
      end else if (load) begin
        pending <= 1'b0;
      end
      if (load) active <= shadow;

      if (base) begin
        pre_cnt <= pre_wrap ? '0 : pre_cnt + PRE_W'(1);
        if (pre_wrap) mod_cnt <= (mod_cnt == m_lim) ? '0 : mod_cnt + M_W'(1);
      end
      if (half) begin
        hck_q    <= ~hck_q;
        fine_cnt <= fine_wrap ? '0 : fine_cnt + F_W'(1);
        if (fine_wrap) sck_q <= ~sck_q;
      end

      sck_pulse  <= half && fine_wrap && !sck_q;
      hck_pad_oe <= drive;
      unique case (mode)
        DM_EXT: begin
          hck_pulse <= ext_en;
          hck_pad   <= 1'b0;
        end
        DM_DIRECT: begin
          hck_pulse <= src_a_en;
          hck_pad   <= src_a_en;
        end
        default: begin
          hck_pulse <= half && !hck_q;
          hck_pad   <= half ? ~hck_q : hck_q;
        end
      endcase
    end
  end

  assign sck_pad = sck_q;

  // Assertions
  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      a_r11_reset_low: assert (!hck_pulse && !hck_pad && !hck_pad_oe && !sck_pulse && !sck_pad)
        else $error("outputs not low after reset");
    end
  end

  a_r4_pad_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    $changed(sck_pad) |-> $past(base));

  a_r4_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
    sck_pulse |-> (sck_pad && !$past(sck_pad)));

  a_r3_div_pulse_high: assert property (@(posedge clk) disable iff (rst)
    ($past(mode == DM_DIV) && hck_pulse) |-> hck_pad);

  a_r5_direct_follow: assert property (@(posedge clk) disable iff (rst)
    $past(mode == DM_DIRECT) |-> (hck_pulse == $past(src_a_en)));

  a_r8_ext_pad_low: assert property (@(posedge clk) disable iff (rst)
    $past(mode == DM_EXT) |-> (!hck_pad && !hck_pad_oe && (hck_pulse == $past(ext_en))));
endmodule

// File: rtl/aclk_div_chain.sv
module aclk_div_chain #(
  parameter int N_PATH = 2,
  parameter int M_W = 8,
  parameter int F_W = 4,
  localparam int CFG_W = M_W + F_W + 4,
  localparam int PATH_W = (N_PATH > 1) ? $clog2(N_PATH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PATH_W-1:0] wr_path,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              src_a_en,
  input  logic              src_b_en,
  input  logic [N_PATH-1:0] ext_hck_en,
  output logic [N_PATH-1:0] hck_pulse,
  output logic [N_PATH-1:0] hck_pad,
  output logic [N_PATH-1:0] hck_pad_oe,
  output logic [N_PATH-1:0] sck_pulse,
  output logic [N_PATH-1:0] sck_pad
);
  logic [N_PATH-1:0] wr_stb;

  aclk_cfg_decode #(.N_PATH(N_PATH)) u_decode (
    .wr_en   (wr_en),
    .wr_path (wr_path),
    .wr_stb  (wr_stb)
  );

  for (genvar g = 0; g < N_PATH; g++) begin : g_path
    aclk_div_path #(.M_W(M_W), .F_W(F_W)) u_path (
      .clk        (clk),
      .rst        (rst),
      .wr_stb     (wr_stb[g]),
      .wr_data    (wr_data),
      .src_a_en   (src_a_en),
      .src_b_en   (src_b_en),
      .ext_en     (ext_hck_en[g]),
      .hck_pulse  (hck_pulse[g]),
      .hck_pad    (hck_pad[g]),
      .hck_pad_oe (hck_pad_oe[g]),
      .sck_pulse  (sck_pulse[g]),
      .sck_pad    (sck_pad[g])
    );
  end
endmodule

// File: tb/aclk_div_chain_bench.sv
`timescale 1ns/1ps
module aclk_div_chain_bench;
  localparam int LIM = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic wr_path = 1'b0;
  logic [15:0] wr_data = '0;
  logic src_a_en = 1'b1;
  logic src_b_en = 1'b0;
  logic ext_rx = 1'b0;
  logic ext_on = 1'b0;
  logic [1:0] hck_pulse, hck_pad, hck_pad_oe, sck_pulse, sck_pad;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  aclk_div_chain u_aclk_div_chain (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_path(wr_path), .wr_data(wr_data),
    .src_a_en(src_a_en), .src_b_en(src_b_en), .ext_hck_en({ext_rx, 1'b0}),
    .hck_pulse(hck_pulse), .hck_pad(hck_pad), .hck_pad_oe(hck_pad_oe),
    .sck_pulse(sck_pulse), .sck_pad(sck_pad)
  );

  // source B every third cycle, external rx clock every second cycle
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      n++;
      src_b_en = (n % 3 == 0);
      ext_rx   = ext_on && (n % 2 == 0);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // setting word per R1
  function automatic logic [15:0] cfg(int m, int f, bit pre8, bit selb, bit drv, bit dir);
    logic [7:0] mf = 8'(m - 1);
    logic [3:0] ff = 4'(f - 1);
    return {dir, drv, selb, pre8, ff, mf};
  endfunction

  task automatic write(input bit path, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_path = path; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // which: 0 tx sck, 1 tx hck, 2 rx sck, 3 rx hck
  function automatic bit pulse_of(int which);
    return which[1] ? (which[0] ? hck_pulse[1] : sck_pulse[1])
                    : (which[0] ? hck_pulse[0] : sck_pulse[0]);
  endfunction
  function automatic bit pad_of(int which);
    return which[1] ? (which[0] ? hck_pad[1] : sck_pad[1])
                    : (which[0] ? hck_pad[0] : sck_pad[0]);
  endfunction

  task automatic wait_pulse(input int which);
    int k = 0;
    @(negedge clk);
    while (!pulse_of(which) && k < LIM) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic meas(input int which, output int per, output int hi);
    wait_pulse(which);
    per = 0; hi = 0;
    for (int k = 0; k < LIM; k++) begin
      if (pad_of(which)) hi++;
      @(negedge clk);
      per++;
      if (pulse_of(which)) break;
    end
  endtask

  task automatic settle(input int which);
    int p, h;
    meas(which, p, h);
    meas(which, p, h);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 outputs low in reset", {hck_pulse, hck_pad, hck_pad_oe, sck_pulse, sck_pad}, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11 outputs low after reset", {hck_pulse, hck_pad, hck_pad_oe, sck_pulse, sck_pad}, 0);
  endtask

  task automatic t_ratio;
    int p, h;
    write(0, cfg(3, 1, 0, 0, 1, 0));
    settle(0);
    meas(0, p, h);
    check("R2 sck period M=3 F=1", p, 6);
    check("R4 sck high M=3 F=1", h, 3);
    meas(1, p, h);
    check("R3 hck period M=3", p, 6);
    check("R8 hck oe when driven", int'(hck_pad_oe[0]), 1);
  endtask

  task automatic t_odd;
    int p, h;
    write(0, cfg(1, 3, 0, 0, 1, 0));
    settle(0);
    meas(0, p, h);
    check("R2 sck period F=3", p, 6);
    check("R4 sck high odd F=3", h, 3);
    meas(1, p, h);
    check("R3 hck period ignores F", p, 2);
  endtask

  task automatic t_pre;
    int p, h;
    write(0, cfg(2, 2, 1, 0, 1, 0));
    settle(0);
    meas(0, p, h);
    check("R1 R2 sck period P=8 M=2 F=2", p, 64);
    check("R4 sck high P=8", h, 32);
    meas(1, p, h);
    check("R3 hck period P=8 M=2", p, 32);
  endtask

  task automatic t_srcb;
    int p, h;
    write(0, cfg(1, 2, 0, 1, 1, 0));
    settle(0);
    meas(0, p, h);
    check("R7 sck period on source B", p, 12);
    check("R7 sck high on source B", h, 6);
  endtask

  task automatic t_direct_a;
    int p, h, n;
    write(0, cfg(2, 1, 0, 0, 1, 1));
    settle(0);
    n = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (hck_pulse[0]) n++;
    end
    check("R5 direct hck follows source A", n, 16);
    meas(0, p, h);
    check("R5 sck still divided in direct", p, 4);
  endtask

  task automatic t_direct_b;
    int p, h;
    write(0, cfg(2, 1, 0, 1, 1, 1));
    settle(0);
    settle(1);
    meas(1, p, h);
    check("R6 direct ignored on source B", p, 12);
  endtask

  task automatic t_ext;
    int p, h, bad;
    write(1, cfg(1, 2, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    ext_on = 1'b1;
    settle(2);
    meas(2, p, h);
    check("R8 sck from external clock", p, 8);
    meas(3, p, h);
    check("R8 hck follows external clock", p, 2);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (hck_pad[1] || hck_pad_oe[1]) bad++;
    end
    check("R8 pad and oe low in input mode", bad, 0);
  endtask

  task automatic t_indep;
    int p, h;
    write(1, cfg(3, 3, 0, 0, 0, 0));
    settle(1);
    meas(1, p, h);
    check("R9 tx hck unchanged by rx write", p, 12);
    settle(2);
    meas(2, p, h);
    check("R9 rx sck takes its own setting", p, 36);
  endtask

  task automatic t_reload;
    int p, h;
    write(0, cfg(2, 2, 0, 0, 1, 0));
    settle(0);
    wait_pulse(0);
    p = 0; h = 0;
    for (int k = 0; k < LIM; k++) begin
      if (sck_pad[0]) h++;
      if (p == 1) begin wr_en = 1'b1; wr_path = 1'b0; wr_data = cfg(1, 1, 0, 0, 1, 0); end
      if (p == 2) wr_en = 1'b0;
      @(negedge clk);
      p++;
      if (sck_pulse[0]) break;
    end
    wr_en = 1'b0;
    check("R10 high phase kept old setting", h, 4);
    check("R10 first period mixes old high and new low", p, 5);
    meas(0, p, h);
    check("R10 new period after falling edge", p, 2);
  endtask

  initial begin
    t_reset();
    t_ratio();
    t_odd();
    t_pre();
    t_srcb();
    t_direct_a();
    t_direct_b();
    t_ext();
    t_indep();
    t_reload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule